// File: doc/BRIEF.md
# IEEE Double Operand Screener

This block inspects one IEEE double-precision operand on its way into a floating-point pipe. It sorts the operand by exponent and fraction into five classes: true zero, denormal, normal finite, infinity and NaN. Then it does one of three things. It passes the operand on untouched, it replaces a denormal with a zero of the same sign, or it signals an arithmetic trap together with a one-hot exception summary. The arithmetic itself and the delivery of the trap belong to other blocks.

Three things steer the policy: the instruction class (ordinary arithmetic or compare), whether software completion is active, and a flush-denormals-to-zero control bit. Compares let infinities through. Software completion never traps and only flushes exponent-zero operands. Each accepted operand gives one registered result a single cycle later, marked by an output valid strobe.

Top module: `fp_operand_screen`

## Requirements
- R1: While reset is low, out_valid, out_trap, out_exc and out_operand are all zero, whatever the inputs are.
- R2: out_valid equals in_valid of the previous cycle. A cycle that follows an idle input cycle has out_trap and out_exc at zero, and out_operand keeps its last value.
- R3: An operand whose exponent field (bits 62:52) is neither all-zeros nor all-ones, and an operand whose exponent and fraction (bits 51:0) are both zero, appear on out_operand unchanged with no trap in every mode.
- R4: In arithmetic or compare mode, a denormal (exponent zero, fraction nonzero) with in_dnz high comes out as its sign bit 63 alone, with every other bit zero and no trap.
- R5: In arithmetic or compare mode, a denormal with in_dnz low raises a trap with out_exc = 5'b01000 (underflow, bit 3). The operand passes unchanged.
- R6: In arithmetic mode, an all-ones exponent with a nonzero fraction (NaN) traps with out_exc = 5'b00001 (invalid, bit 0). An all-ones exponent with a zero fraction (infinity) traps with out_exc = 5'b00100 (overflow, bit 2). The operand passes unchanged.
- R7: In compare mode, an infinity passes with no trap, and a NaN traps with out_exc = 5'b00001.
- R8: In software-completion mode, no trap is ever raised. An operand with a zero exponent becomes its sign bit alone when in_dnz is high. Every other operand passes unchanged.
- R9: in_mode codes: 2'b00 arithmetic, 2'b01 compare, 2'b10 software completion. The code 2'b11 behaves like arithmetic.
- R10: out_exc has at most one bit set. Bit 1 (divide-by-zero) and bit 4 (inexact) are never set. out_trap is high exactly when out_exc is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 64 | IEEE double operand |
| in_mode | input | 2 | Policy select (see R9) |
| in_dnz | input | 1 | Flush denormals to signed zero |
| out_valid | output | 1 | Result present (one cycle after in_valid) |
| out_operand | output | 64 | Screened operand |
| out_trap | output | 1 | Arithmetic trap request |
| out_exc | output | 5 | One-hot exception summary: bit0 invalid, bit1 divide-by-zero, bit2 overflow, bit3 underflow, bit4 inexact |

## Verification
The bench builds the block with its default 11-bit exponent and 52-bit fraction, so every double encoding can be reached, including the extremes of both fields. These are the smallest and largest denormals, signed zeros, both infinities, and NaNs that differ only in the lowest fraction bit. Each class is driven under all four mode codes with the flush bit in both states. Idle cycles are inserted between valid ones, so the held operand and the cleared trap can be seen on the ports.

// File: rtl/screen_pkg.sv
// Package: shared types and constants for the double operand screener.
// Assumes: exception summary is one-hot, bit positions fixed below.
package screen_pkg;

    typedef enum logic [1:0] {
        SCR_ARITH = 2'b00,
        SCR_CMP   = 2'b01,
        SCR_SOFT  = 2'b10,
        SCR_RSVD  = 2'b11
    } scr_mode_e;

    localparam int EXC_W   = 5;
    localparam int EXC_INV = 0;
    localparam int EXC_DZE = 1;
    localparam int EXC_OVF = 2;
    localparam int EXC_UNF = 3;
    localparam int EXC_INE = 4;

    typedef struct packed {
        logic exp_zero;
        logic exp_max;
        logic frac_nz;
    } scr_class_t;

endpackage

// File: rtl/screen_classify.sv
// Module: splits an operand into exponent/fraction predicates.
// Assumes: operand layout is sign | exponent | fraction, MSB first.
module screen_classify #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
    input  logic [DATA_W-1:0]        operand,
    output screen_pkg::scr_class_t   cls
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    // Field extraction and reduction predicates.
    always_comb begin
        exp_f        = operand[DATA_W-2 -: EXP_W];
        frac_f       = operand[FRAC_W-1:0];
        cls.exp_zero = ~|exp_f;
        cls.exp_max  = &exp_f;
        cls.frac_nz  = |frac_f;
    end
endmodule

// File: rtl/screen_policy.sv
// Module: applies the mode-dependent trap and flush policy to a class.
// Assumes: mode 2'b11 follows arithmetic rules; trap is derived from
// the class independently of the exception vector encoding.
module screen_policy (
    input  screen_pkg::scr_class_t      cls,
    input  logic [1:0]                  mode,
    input  logic                        dnz,
    output logic                        flush,
    output logic                        trap,
    output logic [screen_pkg::EXC_W-1:0] exc
);
    import screen_pkg::*;

    scr_mode_e mode_e;
    logic      denorm;
    logic      is_soft;
    logic      is_cmp;

    // Decode mode and the denormal condition.
    always_comb begin
        mode_e  = scr_mode_e'(mode);
        denorm  = cls.exp_zero & cls.frac_nz;
        is_soft = (mode_e == SCR_SOFT);
        is_cmp  = (mode_e == SCR_CMP);
    end

    // Flush and exception selection per mode.
    always_comb begin
        flush = 1'b0;
        exc   = '0;
        case (mode_e)
            SCR_SOFT: flush = cls.exp_zero & dnz;
            default: begin
                if (denorm) begin
                    if (dnz) flush = 1'b1;
                    else     exc[EXC_UNF] = 1'b1;
                end else if (cls.exp_max) begin
                    if (cls.frac_nz)  exc[EXC_INV] = 1'b1;
                    else if (!is_cmp) exc[EXC_OVF] = 1'b1;
                end
            end
        endcase
    end

    // Trap request, formed from the class terms directly.
    always_comb begin
        trap = ~is_soft & ((denorm & ~dnz) |
                           (cls.exp_max & (cls.frac_nz | ~is_cmp)));
    end
endmodule

// File: rtl/fp_operand_screen.sv
// Module: top of the double operand screener; one-cycle registered result.
// Assumes: synchronous active-low reset; idle cycles clear trap/exception
// and hold the last operand.
module fp_operand_screen #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [DATA_W-1:0]            in_operand,
    input  logic [1:0]                   in_mode,
    input  logic                         in_dnz,
    output logic                         out_valid,
    output logic [DATA_W-1:0]            out_operand,
    output logic                         out_trap,
    output logic [screen_pkg::EXC_W-1:0] out_exc
);
    import screen_pkg::*;

    scr_class_t         cls;
    logic               flush;
    logic               trap_c;
    logic [EXC_W-1:0]   exc_c;
    logic [DATA_W-1:0]  screened;

    screen_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_classify (
        .operand (in_operand),
        .cls     (cls)
    );

    screen_policy i_policy (
        .cls   (cls),
        .mode  (in_mode),
        .dnz   (in_dnz),
        .flush (flush),
        .trap  (trap_c),
        .exc   (exc_c)
    );

    // Operand after optional flush to signed zero.
    always_comb begin
        screened = flush ? {in_operand[DATA_W-1], {(DATA_W-1){1'b0}}} : in_operand;
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_operand <= '0;
            out_trap    <= 1'b0;
            out_exc     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_operand <= screened;
                out_trap    <= trap_c;
                out_exc     <= exc_c;
            end else begin
                out_trap    <= 1'b0;
                out_exc     <= '0;
            end
        end
    end
endmodule

// File: rtl/fp_operand_screen_chk.sv
// Module: property checker for the double operand screener, bound below.
// Assumes: same parameters as the screened instance.
module fp_operand_screen_chk #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_operand,
    input logic [1:0]        in_mode,
    input logic              in_dnz,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_operand,
    input logic              out_trap,
    input logic [4:0]        out_exc
);
    logic [EXP_W-1:0] exp_f;
    logic             frac_nz;
    logic             normal;

    // Field predicates seen from the input port.
    always_comb begin
        exp_f   = in_operand[DATA_W-2 -: EXP_W];
        frac_nz = |in_operand[FRAC_W-1:0];
        normal  = (exp_f != '0) && (exp_f != '1);
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_trap && $stable(out_operand)));
    assert_normal_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && normal) |=> (out_operand == $past(in_operand) && !out_trap));
    assert_nan_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && exp_f == '1 && frac_nz && in_mode != 2'b10) |=> out_exc == 5'b00001);
    assert_soft_no_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'b10) |=> !out_trap);
    assert_exc_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_exc) && (out_trap == (out_exc != 5'b0)));
endmodule

bind fp_operand_screen fp_operand_screen_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_operand  (in_operand),
    .in_mode     (in_mode),
    .in_dnz      (in_dnz),
    .out_valid   (out_valid),
    .out_operand (out_operand),
    .out_trap    (out_trap),
    .out_exc     (out_exc)
);

// File: tb/test_fp_operand_screen.sv
module test_fp_operand_screen;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] in_operand;
    logic [1:0]  in_mode;
    logic        in_dnz;
    logic        out_valid;
    logic [63:0] out_operand;
    logic        out_trap;
    logic [4:0]  out_exc;

    int vectors = 0;
    int miscompares = 0;

    // reference model state
    logic        m_valid;
    logic [63:0] m_op;
    logic        m_trap;
    logic [4:0]  m_exc;
    string       m_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_operand_screen i_fp_operand_screen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .in_mode(in_mode), .in_dnz(in_dnz), .out_valid(out_valid),
        .out_operand(out_operand), .out_trap(out_trap), .out_exc(out_exc)
    );

    // Behavioural policy from the requirements.
    function automatic void ref_screen(input logic [63:0] op, input logic [1:0] m,
                                       input logic d, output logic [63:0] res,
                                       output logic [4:0] exc);
        int unsigned e = op[62:52];
        bit fnz = (op[51:0] != 0);
        res = op;
        exc = 5'd0;
        if (m == 2'b10) begin
            if (e == 0 && d) res = {op[63], 63'd0};
        end else if (e == 0 && fnz) begin
            if (d) res = {op[63], 63'd0};
            else   exc = 5'b01000;
        end else if (e == 2047) begin
            if (fnz)            exc = 5'b00001;
            else if (m != 2'b01) exc = 5'b00100;
        end
    endfunction

    task automatic check_now();
        vectors++;
        if (out_valid !== m_valid || out_operand !== m_op ||
            out_trap !== m_trap || out_exc !== m_exc) begin
            miscompares++;
            $display("FAIL %s: valid/op/trap/exc got %b %h %b %b expected %b %h %b %b",
                     m_tag, out_valid, out_operand, out_trap, out_exc,
                     m_valid, m_op, m_trap, m_exc);
        end
    endtask

    task automatic step(input logic v, input logic [63:0] op, input logic [1:0] m,
                        input logic d, input string tag);
        logic [63:0] r;
        logic [4:0]  x;
        @(negedge clk);
        check_now();
        in_valid = v; in_operand = op; in_mode = m; in_dnz = d;
        m_valid = v;
        m_tag = v ? tag : "R2";
        if (v) begin
            ref_screen(op, m, d, r, x);
            m_op = r; m_exc = x; m_trap = (x != 0);
        end else begin
            m_exc = 0; m_trap = 0;
        end
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; in_operand = 64'h7FF0_0000_0000_0000;
        in_mode = 2'b00; in_dnz = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs zero under reset despite valid stimulus
        m_valid = 0; m_op = 0; m_trap = 0; m_exc = 0; m_tag = "R1";
        check_now();
        rst_n = 1'b1; in_valid = 1'b0;
        m_tag = "R2";

        // R3 zero and normal pass
        step(1, 64'h3FF0_0000_0000_0000, 2'b00, 0, "R3");
        step(1, 64'hC004_0000_0000_0000, 2'b01, 1, "R3");
        step(1, 64'h8000_0000_0000_0000, 2'b00, 1, "R3");
        step(1, 64'h7FEF_FFFF_FFFF_FFFF, 2'b00, 0, "R3");
        step(1, 64'h0010_0000_0000_0000, 2'b01, 0, "R3");
        // R4 denormal flush
        step(1, 64'h0000_0000_0000_0001, 2'b00, 1, "R4");
        step(1, 64'h800F_FFFF_FFFF_FFFF, 2'b01, 1, "R4");
        // R5 denormal underflow trap
        step(1, 64'h0000_0000_0000_0001, 2'b00, 0, "R5");
        step(1, 64'h800F_FFFF_FFFF_FFFF, 2'b01, 0, "R5");
        step(0, 64'h0, 2'b00, 0, "R2");
        step(0, 64'h1234_0000_0000_0000, 2'b00, 0, "R2");
        // R6 arithmetic NaN and infinity
        step(1, 64'h7FF8_0000_0000_0000, 2'b00, 0, "R6");
        step(1, 64'h7FF0_0000_0000_0000, 2'b00, 1, "R6");
        step(1, 64'hFFF0_0000_0000_0000, 2'b00, 0, "R6");
        step(1, 64'hFFF0_0000_0000_0001, 2'b00, 0, "R6");
        // R7 compare mode
        step(1, 64'h7FF0_0000_0000_0000, 2'b01, 0, "R7");
        step(1, 64'hFFF0_0000_0000_0000, 2'b01, 1, "R7");
        step(1, 64'hFFF0_0000_0000_0001, 2'b01, 0, "R7");
        // R8 software completion
        step(1, 64'h8000_0000_0000_0005, 2'b10, 1, "R8");
        step(1, 64'h8000_0000_0000_0005, 2'b10, 0, "R8");
        step(1, 64'h7FF8_0000_0000_0000, 2'b10, 0, "R8");
        step(1, 64'h7FF0_0000_0000_0000, 2'b10, 1, "R8");
        step(1, 64'h8000_0000_0000_0000, 2'b10, 1, "R8");
        step(1, 64'h4000_0000_0000_0000, 2'b10, 1, "R8");
        // R9 reserved mode code behaves as arithmetic
        step(1, 64'h7FF0_0000_0000_0000, 2'b11, 0, "R9");
        step(1, 64'h7FF0_0000_0000_0100, 2'b11, 0, "R9");
        step(1, 64'h0000_0000_0000_0100, 2'b11, 0, "R9");
        step(1, 64'h0000_0000_0000_0100, 2'b11, 1, "R9");
        // R10 mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] op;
            int          cat;
            op  = {$urandom(), $urandom()};
            cat = $urandom_range(0, 5);
            case (cat)
                0: op[62:52] = 11'h000;
                1: begin op[62:52] = 11'h000; op[51:0] = 52'd0; end
                2: op[62:52] = 11'h7FF;
                3: begin op[62:52] = 11'h7FF; op[51:0] = 52'd0; end
                default: ;
            endcase
            step(($urandom_range(0, 4) != 0), op, 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), "R10");
        end
        step(0, 64'h0, 2'b00, 0, "R2");
        @(negedge clk);
        check_now();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule